// File: doc/BRIEF.md
# System Control Register Block

This block is the control register window of a small two-core microcontroller subsystem. It answers on a 4 KB APB-style slave port. Software uses it to read why the last reset happened and to keep a word that survives warm resets. It also controls a secure-debug status word through separate set and clear aliases and chooses the address each core boots from. Cores held in reset are released by clearing their wait bits, and a single bit requests a full system reset. A fixed table of identification bytes sits at the top of the window.

A version input selects between a base variant and an extended variant. The extended variant is chosen when the top nibble of the version input is 2. It adds these registers:

- a security-control word;
- two clock-divider words and a clock-force word;
- the second core's boot vector;
- an external-wake control word;
- a system power-sense word;
- a bank of SRAM power-sense words.

The clock, power and wake registers only store what software writes; nothing in the block acts on them. Accesses always complete in the APB access phase with no wait states. Every access is handled as a full 32-bit word: the low two address bits are not decoded, reads are zero-padded and writes use the whole data bus.

Top module: `sysctl_regs`

## Requirements
- R1: After reset the reset-cause word reads 1, the system power-sense word reads 0x7F, the core-hold word reads the HOLD_RST parameter (default 0), both boot vectors read 0x1000_0000, and every other register and output reads 0, including the bad-access flag.
- R2: A write to 0x004 ORs the data into the debug status word at 0x000. A write to 0x008 clears every status bit written as 1. A write to 0x000 leaves the status unchanged.
- R3: Reads of the write-only offsets 0x004, 0x008 and 0x108 return 0.
- R4: A write to the core-hold word at 0x118 behaves as follows:
  - Bit 0 going from 1 to 0 produces a one-cycle high on core_start_o[0], in the cycle after the write's access phase.
  - Bit 1 going from 1 to 0 does the same on core_start_o[1].
  - A bit that stays the same or goes from 0 to 1 produces no pulse.
  - The word then holds the written value.
- R5: A write to 0x108 with bit 9 set produces a one-cycle sys_reset_req_o pulse in the cycle after the access phase. The other bits of that write have no effect.
- R6: With version_i[31:28] not equal to 2, the following offsets read 0 and ignore writes:
  - 0x00C, 0x010, 0x014 and 0x018;
  - 0x114 and 0x124;
  - 0x200, and 0x20C to 0x218.
- R7: The NMI-enable word at 0x11C reads 0 and ignores writes on the base variant. It is read/write on the extended variant.
- R8: Offsets 0xFD0 to 0xFFC read, one byte per word in rising address order: 04, 00, 00, 00, 54, B8, 0B, 00, 0D, F0, 05, B1. Writes to these offsets are ignored.
- R9: boot_vec0_o and boot_vec1_o always equal the stored boot vectors at 0x110 and 0x114. A write to 0x110 or 0x114 shows on the matching output from the next cycle.
- R10: The reset-cause (0x100), reset-mask (0x104), retention (0x10C) and wake-control (0x120) words read back what was last written. On the extended variant, so do the extended words. Each SRAM power-sense word keeps its own value.
- R11: bad_access_o goes high after any access to an unmapped offset, or a write to a read-only offset, and stays high until reset. Valid accesses never set it, and the access that sets it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while a read is selected |
| version_i | input | 32 | Variant tag; top nibble 2 selects the extended map |
| core_start_o | output | 2 | Per-core power-on-and-reset pulse |
| boot_vec0_o | output | 32 | Core 0 initial vector address |
| boot_vec1_o | output | 32 | Core 1 initial vector address |
| sys_reset_req_o | output | 1 | One-cycle system reset request |
| bad_access_o | output | 1 | Sticky flag for invalid accesses |

## Verification
The bench concentrates on the following cases:

- The hold word is written in every bit-transition pattern. A design that pulsed on level rather than on a 1-to-0 edge, or pulsed on 0-to-1, would show a pulse where none is expected. A pulse longer than one cycle is caught by sampling the following cycle.
- The set and clear aliases are applied on top of an already nonzero status word. This exposes an alias that overwrites instead of merging, and a status word that accepts direct writes.
- Every extended-only offset is exercised on the base variant. A decoder that forgot to gate one of them would return stored data there or move the second boot vector.
- The reserved reset bits and the read-only ID and status writes are checked. A design that decoded the wrong reset bit, or let a read-only write through, would disturb state that the bench reads back.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
// Shared constants, register select codes and the identification table
// for the system control register block. Assumes 32-bit words and a 4 KB
// byte-addressed window.
package sysctl_pkg;

    localparam int WORD_W = 32;
    localparam int OFS_W  = 12;

    // Byte offsets that software and the bench rely on.
    localparam logic [OFS_W-1:0] OFS_DBG_STAT  = 12'h000;
    localparam logic [OFS_W-1:0] OFS_DBG_SET   = 12'h004;
    localparam logic [OFS_W-1:0] OFS_DBG_CLR   = 12'h008;
    localparam logic [OFS_W-1:0] OFS_SEC_CTL   = 12'h00C;
    localparam logic [OFS_W-1:0] OFS_FCLK      = 12'h010;
    localparam logic [OFS_W-1:0] OFS_SCLK      = 12'h014;
    localparam logic [OFS_W-1:0] OFS_CLK_FORCE = 12'h018;
    localparam logic [OFS_W-1:0] OFS_RST_CAUSE = 12'h100;
    localparam logic [OFS_W-1:0] OFS_RST_MASK  = 12'h104;
    localparam logic [OFS_W-1:0] OFS_SW_RST    = 12'h108;
    localparam logic [OFS_W-1:0] OFS_RETAIN    = 12'h10C;
    localparam logic [OFS_W-1:0] OFS_BOOT0     = 12'h110;
    localparam logic [OFS_W-1:0] OFS_BOOT1     = 12'h114;
    localparam logic [OFS_W-1:0] OFS_HOLD      = 12'h118;
    localparam logic [OFS_W-1:0] OFS_NMI       = 12'h11C;
    localparam logic [OFS_W-1:0] OFS_WAKE_IC   = 12'h120;
    localparam logic [OFS_W-1:0] OFS_EXT_WAKE  = 12'h124;
    localparam logic [OFS_W-1:0] OFS_PWR_SYS   = 12'h200;
    localparam logic [OFS_W-1:0] OFS_PWR_RAM   = 12'h20C;
    localparam logic [OFS_W-1:0] OFS_ID_BASE   = 12'hFD0;

    localparam int               SWRST_BIT   = 9;
    localparam logic [3:0]       EXT_TAG     = 4'h2;
    localparam logic [WORD_W-1:0] CAUSE_RST  = 32'h0000_0001;
    localparam logic [WORD_W-1:0] PWR_SYS_RST = 32'h0000_007F;

    typedef enum logic [4:0] {
        SEL_NONE, SEL_DBG_STAT, SEL_DBG_SET, SEL_DBG_CLR, SEL_SEC_CTL,
        SEL_FCLK, SEL_SCLK, SEL_CLK_FORCE, SEL_RST_CAUSE, SEL_RST_MASK,
        SEL_SW_RST, SEL_RETAIN, SEL_BOOT0, SEL_BOOT1, SEL_HOLD, SEL_NMI,
        SEL_WAKE_IC, SEL_EXT_WAKE, SEL_PWR_SYS, SEL_PWR_RAM, SEL_ID
    } sel_e;

    // Identification byte for word k of the ID area (k = 0 at 0xFD0).
    function automatic logic [7:0] id_byte(input logic [3:0] k);
        case (k)
            4'd0:    id_byte = 8'h04;
            4'd4:    id_byte = 8'h54;
            4'd5:    id_byte = 8'hB8;
            4'd6:    id_byte = 8'h0B;
            4'd8:    id_byte = 8'h0D;
            4'd9:    id_byte = 8'hF0;
            4'd10:   id_byte = 8'h05;
            4'd11:   id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_addr_map.sv
`timescale 1ns/1ps
// Address decoder. Maps a byte offset to a register select code, given the
// active variant. Extended-only registers decode as SEL_NONE on the base
// variant. Also reports read-only and write-only classes, the SRAM bank
// index and the ID word index. Assumes word-aligned decoding (low two
// address bits are not decoded).
module sysctl_addr_map
    import sysctl_pkg::*;
#(
    parameter int NUM_RAM = 4,
    parameter int RIDX_W  = (NUM_RAM > 1) ? $clog2(NUM_RAM) : 1
) (
    input  logic [OFS_W-1:0]  addr_i,
    input  logic              ext_i,
    output sel_e              sel_o,
    output logic [RIDX_W-1:0] ram_idx_o,
    output logic [3:0]        id_idx_o,
    output logic              read_only_o,
    output logic              write_only_o
);

    localparam int WA_W = OFS_W - 2;
    localparam logic [WA_W-1:0] RAM_W = OFS_PWR_RAM[OFS_W-1:2];
    localparam logic [WA_W-1:0] ID_W  = OFS_ID_BASE[OFS_W-1:2];

    logic [WA_W-1:0] word;
    logic [WA_W-1:0] ram_rel;
    logic [WA_W-1:0] id_rel;
    logic            unused_low;
    sel_e            raw_sel;
    logic            ext_only;

    assign word       = addr_i[OFS_W-1:2];
    assign unused_low = ^addr_i[1:0];
    assign ram_rel    = word - RAM_W;
    assign id_rel     = word - ID_W;
    assign ram_idx_o  = ram_rel[RIDX_W-1:0];
    assign id_idx_o   = id_rel[3:0];

    // Raw decode of the word address, ignoring the variant.
    always_comb begin
        case (word)
            OFS_DBG_STAT[OFS_W-1:2]:  raw_sel = SEL_DBG_STAT;
            OFS_DBG_SET[OFS_W-1:2]:   raw_sel = SEL_DBG_SET;
            OFS_DBG_CLR[OFS_W-1:2]:   raw_sel = SEL_DBG_CLR;
            OFS_SEC_CTL[OFS_W-1:2]:   raw_sel = SEL_SEC_CTL;
            OFS_FCLK[OFS_W-1:2]:      raw_sel = SEL_FCLK;
            OFS_SCLK[OFS_W-1:2]:      raw_sel = SEL_SCLK;
            OFS_CLK_FORCE[OFS_W-1:2]: raw_sel = SEL_CLK_FORCE;
            OFS_RST_CAUSE[OFS_W-1:2]: raw_sel = SEL_RST_CAUSE;
            OFS_RST_MASK[OFS_W-1:2]:  raw_sel = SEL_RST_MASK;
            OFS_SW_RST[OFS_W-1:2]:    raw_sel = SEL_SW_RST;
            OFS_RETAIN[OFS_W-1:2]:    raw_sel = SEL_RETAIN;
            OFS_BOOT0[OFS_W-1:2]:     raw_sel = SEL_BOOT0;
            OFS_BOOT1[OFS_W-1:2]:     raw_sel = SEL_BOOT1;
            OFS_HOLD[OFS_W-1:2]:      raw_sel = SEL_HOLD;
            OFS_NMI[OFS_W-1:2]:       raw_sel = SEL_NMI;
            OFS_WAKE_IC[OFS_W-1:2]:   raw_sel = SEL_WAKE_IC;
            OFS_EXT_WAKE[OFS_W-1:2]:  raw_sel = SEL_EXT_WAKE;
            OFS_PWR_SYS[OFS_W-1:2]:   raw_sel = SEL_PWR_SYS;
            default: begin
                if (word >= RAM_W && ram_rel < WA_W'(NUM_RAM))
                    raw_sel = SEL_PWR_RAM;
                else if (word >= ID_W)
                    raw_sel = SEL_ID;
                else
                    raw_sel = SEL_NONE;
            end
        endcase
    end

    // Gate extended-only registers by variant and classify access rights.
    always_comb begin
        ext_only = raw_sel inside {SEL_SEC_CTL, SEL_FCLK, SEL_SCLK, SEL_CLK_FORCE,
                                   SEL_BOOT1, SEL_EXT_WAKE, SEL_PWR_SYS, SEL_PWR_RAM};
        sel_o        = (ext_only && !ext_i) ? SEL_NONE : raw_sel;
        read_only_o  = (sel_o inside {SEL_DBG_STAT, SEL_ID}) || (sel_o == SEL_NMI && !ext_i);
        write_only_o = sel_o inside {SEL_DBG_SET, SEL_DBG_CLR, SEL_SW_RST};
    end

endmodule

// File: rtl/sysctl_regs.sv
`timescale 1ns/1ps
// System control register block. APB-style slave with zero wait states:
// writes commit on the clock edge that ends the access phase, read data is
// combinational from the address while a read is selected. Holds reset,
// debug, boot and hold-off control words, produces one-cycle core start and
// system reset pulses, and raises a sticky flag on invalid accesses.
// Assumes a synchronous active-low reset and full-word accesses.
module sysctl_regs
    import sysctl_pkg::*;
#(
    parameter logic [31:0] HOLD_RST  = 32'h0000_0000,
    parameter logic [31:0] BOOT0_RST = 32'h1000_0000,
    parameter logic [31:0] BOOT1_RST = 32'h1000_0000,
    parameter int          NUM_RAM   = 4
) (
    input  logic        pclk,
    input  logic        presetn,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [11:0] paddr,
    input  logic [31:0] pwdata,
    output logic [31:0] prdata,
    input  logic [31:0] version_i,
    output logic [1:0]  core_start_o,
    output logic [31:0] boot_vec0_o,
    output logic [31:0] boot_vec1_o,
    output logic        sys_reset_req_o,
    output logic        bad_access_o
);

    localparam int NUM_CORES = 2;
    localparam int RIDX_W    = (NUM_RAM > 1) ? $clog2(NUM_RAM) : 1;

    sel_e              sel;
    logic [RIDX_W-1:0] ram_idx;
    logic [3:0]        id_idx;
    logic              read_only;
    logic              write_only;
    logic              ext;
    logic              unused_version;
    logic              access;
    logic              wr_en;
    logic [31:0]       rdata;

    logic [WORD_W-1:0] dbg_q, sec_q, fclk_q, sclk_q, force_q, cause_q, mask_q;
    logic [WORD_W-1:0] retain_q, boot0_q, boot1_q, hold_q, nmi_q, wake_q, ewake_q;
    logic [WORD_W-1:0] pwr_sys_q;
    logic [WORD_W-1:0] pwr_ram_q [NUM_RAM];
    logic              sysrst_q;
    logic              bad_q;

    assign ext            = (version_i[31:28] == EXT_TAG);
    assign unused_version = ^version_i[27:0];
    assign access         = psel && penable;
    assign wr_en          = access && pwrite;

    sysctl_addr_map #(.NUM_RAM(NUM_RAM), .RIDX_W(RIDX_W)) i_map (
        .addr_i      (paddr),
        .ext_i       (ext),
        .sel_o       (sel),
        .ram_idx_o   (ram_idx),
        .id_idx_o    (id_idx),
        .read_only_o (read_only),
        .write_only_o(write_only)
    );

    // Register file update on a committed write.
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            dbg_q     <= '0;
            sec_q     <= '0;
            fclk_q    <= '0;
            sclk_q    <= '0;
            force_q   <= '0;
            cause_q   <= CAUSE_RST;
            mask_q    <= '0;
            retain_q  <= '0;
            boot0_q   <= BOOT0_RST;
            boot1_q   <= BOOT1_RST;
            hold_q    <= HOLD_RST;
            nmi_q     <= '0;
            wake_q    <= '0;
            ewake_q   <= '0;
            pwr_sys_q <= PWR_SYS_RST;
            for (int b = 0; b < NUM_RAM; b++) pwr_ram_q[b] <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DBG_SET:   dbg_q     <= dbg_q | pwdata;
                SEL_DBG_CLR:   dbg_q     <= dbg_q & ~pwdata;
                SEL_SEC_CTL:   sec_q     <= pwdata;
                SEL_FCLK:      fclk_q    <= pwdata;
                SEL_SCLK:      sclk_q    <= pwdata;
                SEL_CLK_FORCE: force_q   <= pwdata;
                SEL_RST_CAUSE: cause_q   <= pwdata;
                SEL_RST_MASK:  mask_q    <= pwdata;
                SEL_RETAIN:    retain_q  <= pwdata;
                SEL_BOOT0:     boot0_q   <= pwdata;
                SEL_BOOT1:     boot1_q   <= pwdata;
                SEL_HOLD:      hold_q    <= pwdata;
                SEL_NMI:       if (!read_only) nmi_q <= pwdata;
                SEL_WAKE_IC:   wake_q    <= pwdata;
                SEL_EXT_WAKE:  ewake_q   <= pwdata;
                SEL_PWR_SYS:   pwr_sys_q <= pwdata;
                SEL_PWR_RAM:   pwr_ram_q[ram_idx] <= pwdata;
                default: ;
            endcase
        end
    end

    // One start pulse per core on a 1-to-0 transition of its hold bit.
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic start_q;
        always_ff @(posedge pclk) begin
            if (!presetn) start_q <= 1'b0;
            else          start_q <= wr_en && (sel == SEL_HOLD) && hold_q[c] && !pwdata[c];
        end
        assign core_start_o[c] = start_q;
    end

    // System reset request pulse from the request bit of the reset word.
    always_ff @(posedge pclk) begin
        if (!presetn) sysrst_q <= 1'b0;
        else          sysrst_q <= wr_en && (sel == SEL_SW_RST) && pwdata[SWRST_BIT];
    end

    // Sticky flag for unmapped accesses and writes to read-only offsets.
    always_ff @(posedge pclk) begin
        if (!presetn)
            bad_q <= 1'b0;
        else if (access && ((sel == SEL_NONE) || (pwrite && read_only)))
            bad_q <= 1'b1;
    end

    // Read data selection; write-only and unmapped offsets return zero.
    always_comb begin
        case (sel)
            SEL_DBG_STAT:  rdata = dbg_q;
            SEL_SEC_CTL:   rdata = sec_q;
            SEL_FCLK:      rdata = fclk_q;
            SEL_SCLK:      rdata = sclk_q;
            SEL_CLK_FORCE: rdata = force_q;
            SEL_RST_CAUSE: rdata = cause_q;
            SEL_RST_MASK:  rdata = mask_q;
            SEL_RETAIN:    rdata = retain_q;
            SEL_BOOT0:     rdata = boot0_q;
            SEL_BOOT1:     rdata = boot1_q;
            SEL_HOLD:      rdata = hold_q;
            SEL_NMI:       rdata = read_only ? '0 : nmi_q;
            SEL_WAKE_IC:   rdata = wake_q;
            SEL_EXT_WAKE:  rdata = ewake_q;
            SEL_PWR_SYS:   rdata = pwr_sys_q;
            SEL_PWR_RAM:   rdata = pwr_ram_q[ram_idx];
            SEL_ID:        rdata = {24'd0, id_byte(id_idx)};
            default:       rdata = '0;
        endcase
        if (write_only) rdata = '0;
    end

    assign prdata          = (psel && !pwrite) ? rdata : '0;
    assign boot_vec0_o     = boot0_q;
    assign boot_vec1_o     = boot1_q;
    assign sys_reset_req_o = sysrst_q;
    assign bad_access_o    = bad_q;

endmodule

// File: rtl/sysctl_regs_checker.sv
`timescale 1ns/1ps
// Temporal checks on the ports of sysctl_regs, bound to every instance.
// Assumes the byte offsets of the register map in sysctl_pkg.
module sysctl_regs_checker (
    input logic        pclk,
    input logic        presetn,
    input logic        psel,
    input logic        penable,
    input logic        pwrite,
    input logic [11:0] paddr,
    input logic [31:0] pwdata,
    input logic [31:0] prdata,
    input logic [31:0] version_i,
    input logic [1:0]  core_start_o,
    input logic [31:0] boot_vec0_o,
    input logic        sys_reset_req_o,
    input logic        bad_access_o
);

    logic wr;
    logic rd;
    assign wr = psel && penable && pwrite;
    assign rd = psel && !pwrite;

    assert_core0_single_R4: assert property (@(posedge pclk) disable iff (!presetn)
        core_start_o[0] |=> !core_start_o[0]);

    assert_core1_single_R4: assert property (@(posedge pclk) disable iff (!presetn)
        core_start_o[1] |=> !core_start_o[1]);

    assert_core_cause_R4: assert property (@(posedge pclk) disable iff (!presetn)
        (|core_start_o) |-> $past(wr && paddr[11:2] == 10'h046));

    assert_sysrst_cause_R5: assert property (@(posedge pclk) disable iff (!presetn)
        sys_reset_req_o |-> $past(wr && paddr[11:2] == 10'h042 && pwdata[9]));

    assert_sysrst_single_R5: assert property (@(posedge pclk) disable iff (!presetn)
        sys_reset_req_o |=> !sys_reset_req_o);

    assert_wo_read_zero_R3: assert property (@(posedge pclk) disable iff (!presetn)
        (rd && (paddr[11:2] == 10'h001 || paddr[11:2] == 10'h002 ||
                paddr[11:2] == 10'h042)) |-> (prdata == 32'd0));

    assert_nmi_base_zero_R7: assert property (@(posedge pclk) disable iff (!presetn)
        (rd && paddr[11:2] == 10'h047 && version_i[31:28] != 4'h2) |-> (prdata == 32'd0));

    assert_bad_sticky_R11: assert property (@(posedge pclk) disable iff (!presetn)
        bad_access_o |=> bad_access_o);

    assert_boot0_load_R9: assert property (@(posedge pclk) disable iff (!presetn)
        (wr && paddr[11:2] == 10'h044) |=> (boot_vec0_o == $past(pwdata)));

endmodule

bind sysctl_regs sysctl_regs_checker i_checker (
    .pclk           (pclk),
    .presetn        (presetn),
    .psel           (psel),
    .penable        (penable),
    .pwrite         (pwrite),
    .paddr          (paddr),
    .pwdata         (pwdata),
    .prdata         (prdata),
    .version_i      (version_i),
    .core_start_o   (core_start_o),
    .boot_vec0_o    (boot_vec0_o),
    .sys_reset_req_o(sys_reset_req_o),
    .bad_access_o   (bad_access_o)
);

// File: tb/test_sysctl_regs.sv
`timescale 1ns/1ps
// Directed bench for sysctl_regs: one task per scenario, each checking its
// own results against values taken from the requirements.
module test_sysctl_regs;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [31:0] version_i = '0;
    logic [1:0]  core_start_o;
    logic [31:0] boot_vec0_o;
    logic [31:0] boot_vec1_o;
    logic        sys_reset_req_o;
    logic        bad_access_o;

    int   checks = 0;
    int   errors = 0;
    logic done = 1'b0;
    logic [1:0] seen_start, after_start;
    logic       seen_rst, after_rst;

    always #2 pclk = ~pclk;

    sysctl_regs i_sysctl_regs (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .version_i(version_i), .core_start_o(core_start_o),
        .boot_vec0_o(boot_vec0_o), .boot_vec1_o(boot_vec1_o),
        .sys_reset_req_o(sys_reset_req_o), .bad_access_o(bad_access_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge pclk);
        presetn = 1'b0;
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        seen_start = core_start_o; seen_rst = sys_reset_req_o;
        @(negedge pclk);
        after_start = core_start_o; after_rst = sys_reset_req_o;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge pclk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    task automatic t_reset_values_base();
        read_check("R1 debug status", 12'h000, 32'h0);
        read_check("R1 reset cause", 12'h100, 32'h1);
        read_check("R1 reset mask", 12'h104, 32'h0);
        read_check("R1 retention", 12'h10C, 32'h0);
        read_check("R1 boot0", 12'h110, 32'h1000_0000);
        read_check("R1 hold", 12'h118, 32'h0);
        read_check("R1 wake ctl", 12'h120, 32'h0);
        check("R1 boot_vec0_o", boot_vec0_o, 32'h1000_0000);
        check("R1 boot_vec1_o", boot_vec1_o, 32'h1000_0000);
        check("R1 core_start_o", {30'd0, core_start_o}, 32'h0);
        check("R1 sys_reset_req_o", {31'd0, sys_reset_req_o}, 32'h0);
        check("R1 bad_access_o", {31'd0, bad_access_o}, 32'h0);
    endtask

    task automatic t_bad_flag();
        bus_write(12'h10C, 32'h1234_5678);
        read_check("R11 valid access", 12'h10C, 32'h1234_5678);
        check("R11 clear after valid", {31'd0, bad_access_o}, 32'h0);
        bus_write(12'h3F0, 32'hFFFF_FFFF);
        check("R11 set by unmapped write", {31'd0, bad_access_o}, 32'h1);
        read_check("R11 unmapped write no effect", 12'h10C, 32'h1234_5678);
        bus_write(12'h104, 32'h5);
        check("R11 sticky", {31'd0, bad_access_o}, 32'h1);
    endtask

    task automatic t_base_variant();
        bus_write(12'h010, 32'h5);
        read_check("R6 base fclk", 12'h010, 32'h0);
        bus_write(12'h00C, 32'h7);
        read_check("R6 base sec ctl", 12'h00C, 32'h0);
        bus_write(12'h114, 32'h2000_0000);
        read_check("R6 base boot1", 12'h114, 32'h0);
        check("R6 base boot_vec1_o", boot_vec1_o, 32'h1000_0000);
        read_check("R6 base pwr sys", 12'h200, 32'h0);
        bus_write(12'h210, 32'h9);
        read_check("R6 base pwr ram", 12'h210, 32'h0);
        bus_write(12'h11C, 32'hFF);
        read_check("R7 base nmi", 12'h11C, 32'h0);
    endtask

    task automatic t_ext_reset();
        check("R1 ext bad_access_o", {31'd0, bad_access_o}, 32'h0);
        read_check("R1 pwr sys", 12'h200, 32'h7F);
        read_check("R1 boot1", 12'h114, 32'h1000_0000);
        read_check("R1 pwr ram", 12'h214, 32'h0);
    endtask

    task automatic t_ext_variant();
        bus_write(12'h00C, 32'h11);
        bus_write(12'h010, 32'h22);
        bus_write(12'h014, 32'h33);
        bus_write(12'h018, 32'h44);
        bus_write(12'h124, 32'h55);
        bus_write(12'h200, 32'h3);
        for (int b = 0; b < 4; b++) bus_write(12'h20C + 12'(4 * b), 32'hA0 + 32'(b));
        read_check("R10 sec ctl", 12'h00C, 32'h11);
        read_check("R10 fclk", 12'h010, 32'h22);
        read_check("R10 sclk", 12'h014, 32'h33);
        read_check("R10 clk force", 12'h018, 32'h44);
        read_check("R10 ext wake", 12'h124, 32'h55);
        read_check("R10 pwr sys", 12'h200, 32'h3);
        for (int b = 0; b < 4; b++) read_check("R10 pwr ram bank", 12'h20C + 12'(4 * b), 32'hA0 + 32'(b));
        bus_write(12'h11C, 32'h1);
        read_check("R7 ext nmi", 12'h11C, 32'h1);
        check("R6 ext no bad flag", {31'd0, bad_access_o}, 32'h0);
    endtask

    task automatic t_debug_alias();
        bus_write(12'h004, 32'h0000_00F0);
        read_check("R2 set", 12'h000, 32'hF0);
        bus_write(12'h004, 32'h0000_000F);
        read_check("R2 set merges", 12'h000, 32'hFF);
        bus_write(12'h008, 32'h0000_003C);
        read_check("R2 clear", 12'h000, 32'hC3);
        bus_write(12'h000, 32'hFFFF_FFFF);
        read_check("R2 status read-only", 12'h000, 32'hC3);
    endtask

    task automatic t_wo_reads();
        read_check("R3 set alias read", 12'h004, 32'h0);
        read_check("R3 clear alias read", 12'h008, 32'h0);
        read_check("R3 soft reset read", 12'h108, 32'h0);
    endtask

    task automatic t_core_release();
        bus_write(12'h118, 32'h3);
        check("R4 0-to-1 no pulse", {30'd0, seen_start}, 32'h0);
        read_check("R4 hold value", 12'h118, 32'h3);
        bus_write(12'h118, 32'h2);
        check("R4 core0 pulse", {30'd0, seen_start}, 32'h1);
        check("R4 core0 one cycle", {30'd0, after_start}, 32'h0);
        bus_write(12'h118, 32'h2);
        check("R4 unchanged no pulse", {30'd0, seen_start}, 32'h0);
        bus_write(12'h118, 32'h0);
        check("R4 core1 pulse", {30'd0, seen_start}, 32'h2);
        bus_write(12'h118, 32'h3);
        bus_write(12'h118, 32'hFFFF_FFFC);
        check("R4 both pulse", {30'd0, seen_start}, 32'h3);
        check("R4 both one cycle", {30'd0, after_start}, 32'h0);
        read_check("R4 hold takes value", 12'h118, 32'hFFFF_FFFC);
    endtask

    task automatic t_soft_reset();
        bus_write(12'h108, 32'hFFFF_FDFF);
        check("R5 reserved bits", {31'd0, seen_rst}, 32'h0);
        bus_write(12'h108, 32'h0000_0200);
        check("R5 request", {31'd0, seen_rst}, 32'h1);
        check("R5 one cycle", {31'd0, after_rst}, 32'h0);
    endtask

    task automatic t_id_area();
        logic [7:0] exp_id [12];
        exp_id = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h54, 8'hB8,
                   8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int k = 0; k < 12; k++)
            read_check("R8 id byte", 12'hFD0 + 12'(4 * k), {24'd0, exp_id[k]});
        bus_write(12'hFD0, 32'hFF);
        read_check("R8 id write ignored", 12'hFD0, 32'h04);
    endtask

    task automatic t_boot_vec();
        bus_write(12'h110, 32'h0800_0000);
        check("R9 boot_vec0_o", boot_vec0_o, 32'h0800_0000);
        bus_write(12'h114, 32'h2000_0400);
        check("R9 boot_vec1_o", boot_vec1_o, 32'h2000_0400);
        read_check("R9 boot1 readback", 12'h114, 32'h2000_0400);
    endtask

    task automatic t_plain_rw();
        bus_write(12'h100, 32'hA5A5_0000);
        bus_write(12'h104, 32'h0000_5A5A);
        bus_write(12'h10C, 32'hDEAD_BEEF);
        bus_write(12'h120, 32'h0000_0003);
        read_check("R10 reset cause", 12'h100, 32'hA5A5_0000);
        read_check("R10 reset mask", 12'h104, 32'h0000_5A5A);
        read_check("R10 retention", 12'h10C, 32'hDEAD_BEEF);
        read_check("R10 wake ctl", 12'h120, 32'h0000_0003);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge pclk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        version_i = 32'h0000_0000;
        do_reset();
        t_reset_values_base();
        t_bad_flag();
        t_base_variant();

        version_i = 32'h2000_0000;
        do_reset();
        t_ext_reset();
        t_ext_variant();
        t_debug_alias();
        t_wo_reads();
        t_core_release();
        t_soft_reset();
        t_id_area();
        t_boot_vec();
        t_plain_rw();

        done = 1'b1;
        finish_run();
    end

endmodule